// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a synchronous requester and an external asynchronous static RAM of 512K sixteen-bit words. It accepts one request at a time over a valid/ready handshake, turns it into a sequence of registered memory strobes (two chip selects, write strobe, output enable and two active-low byte lane enables), and returns read data with a one-cycle valid pulse. The memory data bus is split into an output value, an output enable and an input value, so that a tristate pad outside the block can join them.

All memory timing is given as nanosecond parameters and turned into whole clock counts by rounding up. A write first selects the device and lanes with the output enable high and the drivers off for a turnaround interval. Then the write strobe falls and data is driven for the pulse interval. The strobe rises while data and address are held for one more cycle, and the device is deselected for whatever recovery the write cycle time still needs. A read lowers the output enable together with the selects and captures the bus after the access count. After reset, ready stays low until a startup count has run out. Back-pressure: the requester keeps `req_valid` and all request fields steady while `req_ready` is low, and a request is taken on the clock edge where both are high.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low for ceil(T_BOOT_NS/CLK_NS)+1 clock edges and goes high on the next one; the memory stays parked during that time.
- R2: A request is accepted on an edge with `req_valid` and `req_ready` high. `req_ready` then stays low for ceil(T_AA_NS/CLK_NS) cycles for a read, and for max(turnaround+pulse+1, ceil(T_WC_NS/CLK_NS)) cycles for a write. No request is taken while ready is low.
- R3: Whenever `req_ready` is high, the memory is parked: `mem_ce1_n`, `mem_we_n`, `mem_oe_n`, `mem_ub_n`, `mem_lb_n` high, `mem_ce2` low, `dq_oe` low.
- R4: In a write, the selects and lanes are set with `mem_oe_n` high and `dq_oe` low for at least T_HZWE_NS before `mem_we_n` falls. When `mem_we_n` falls, `dq_oe` rises. When `mem_we_n` rises, `dq_oe`, `dq_out` and `mem_addr` are held for one more cycle.
- R5: `req_be` bit 0 set drives `mem_lb_n` low and selects data bits 7..0; bit 1 set drives `mem_ub_n` low and selects bits 15..8. A write with one lane set leaves the other byte of that word unchanged.
- R6: A read drives `mem_oe_n` low together with the selects and captures `dq_in` on the edge that ends the access count. `rsp_valid` is high for exactly that one cycle, and `rsp_data` holds the captured word.
- R7: `dq_oe` is never high while `mem_oe_n` is low.
- R8: In every write, `mem_we_n` is low for at least T_PWE_NS. Write data is driven and stable for at least T_SD_NS before `mem_we_n` rises. The address is stable with the device selected for at least T_AW_NS before that edge. Successive accesses that follow a write start at least T_WC_NS apart.
- R9: During an access `mem_ce1_n` is low and `mem_ce2` is high; `mem_addr` carries the request address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_be | input | 2 | Lane enables, bit 1 upper byte, bit 0 lower byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | DATA_W | Read data |
| mem_ce1_n | output | 1 | Active-low chip select |
| mem_ce2 | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper byte enable |
| mem_lb_n | output | 1 | Active-low lower byte enable |
| mem_addr | output | ADDR_W | Memory address |
| dq_out | output | DATA_W | Data toward the pad |
| dq_oe | output | 1 | Pad driver enable |
| dq_in | input | DATA_W | Data from the pad |

## Verification
The bench builds the block with a 20 ns clock, the fastest grade's strobe timings, a 500 ns startup time and a 130 ns write cycle time. The short startup makes the boot count observable within a short run. The stretched write cycle forces a three-cycle recovery phase that the default timings would skip, so the write length is set by the cycle-time rule rather than by the strobe phases. With these values, the write strobe and data-setup minimums both round up to two cycles, and the read access rounds to three.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_BOOT, ST_IDLE, ST_TURN, ST_PULSE, ST_HOLD, ST_READ, ST_RECOV
  } sram_st_e;

  // Round a nanosecond figure up to whole clocks, never below one.
  function automatic int ns2cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_dly_cnt.sv
module sram_dly_cnt #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R1
  cnt_settles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && done) |=> done);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int CLK_NS      = 20,
  parameter int T_WC_NS     = 45,
  parameter int T_PWE_NS    = 35,
  parameter int T_AW_NS     = 40,
  parameter int T_SD_NS     = 25,
  parameter int T_AA_NS     = 45,
  parameter int T_HZWE_NS   = 15,
  parameter int T_BOOT_NS   = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [DATA_W-1:0] dq_in
);

  localparam int HZ_CYC   = ns2cyc(T_HZWE_NS, CLK_NS);
  localparam int PW_CYC   = imax(imax(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SD_NS, CLK_NS)),
                                 imax(ns2cyc(T_AW_NS, CLK_NS) - HZ_CYC, 1));
  localparam int WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
  localparam int WBODY    = HZ_CYC + PW_CYC + 1;
  localparam int REC_CYC  = (WC_CYC > WBODY) ? (WC_CYC - WBODY) : 0;
  localparam int AA_CYC   = ns2cyc(T_AA_NS, CLK_NS);
  localparam int BOOT_CYC = ns2cyc(T_BOOT_NS, CLK_NS);
  localparam int PH_MAX   = imax(imax(HZ_CYC, PW_CYC), imax(AA_CYC, REC_CYC));
  localparam int PH_W     = $clog2(PH_MAX + 2);
  localparam int BOOT_W   = $clog2(BOOT_CYC + 2);

  sram_st_e          state;
  logic              boot_done;
  logic              ph_done;
  logic              ph_load;
  logic [PH_W-1:0]   ph_val;
  logic              accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  sram_dly_cnt #(.W(BOOT_W), .RST_VAL(BOOT_CYC)) u_boot (
    .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0), .done(boot_done)
  );

  sram_dly_cnt #(.W(PH_W), .RST_VAL(0)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
  );

  // Each phase of N cycles loads N-1 on entry.
  always_comb begin
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state)
      ST_IDLE: if (accept) begin
        ph_load = 1'b1;
        ph_val  = req_write ? PH_W'(HZ_CYC - 1) : PH_W'(AA_CYC - 1);
      end
      ST_TURN: if (ph_done) begin
        ph_load = 1'b1;
        ph_val  = PH_W'(PW_CYC - 1);
      end
      ST_HOLD: begin
        ph_load = (REC_CYC > 0);
        ph_val  = (REC_CYC > 0) ? PH_W'(REC_CYC - 1) : '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_BOOT;
      mem_ce1_n <= 1'b1;
      mem_ce2   <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_addr  <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_BOOT: if (boot_done) state <= ST_IDLE;
        ST_IDLE: if (accept) begin
          mem_addr  <= req_addr;
          mem_ce1_n <= 1'b0;
          mem_ce2   <= 1'b1;
          mem_ub_n  <= ~req_be[1];
          mem_lb_n  <= ~req_be[0];
          dq_out    <= req_wdata;
          if (req_write) begin
            state <= ST_TURN;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= ST_READ;
          end
        end
        ST_TURN: if (ph_done) begin
          mem_we_n <= 1'b0;
          dq_oe    <= 1'b1;
          state    <= ST_PULSE;
        end
        ST_PULSE: if (ph_done) begin
          mem_we_n <= 1'b1;
          state    <= ST_HOLD;
        end
        ST_HOLD: begin
          mem_ce1_n <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          dq_oe     <= 1'b0;
          state     <= (REC_CYC > 0) ? ST_RECOV : ST_IDLE;
        end
        ST_READ: if (ph_done) begin
          rsp_data  <= dq_in;
          rsp_valid <= 1'b1;
          mem_ce1_n <= 1'b1;
          mem_ce2   <= 1'b0;
          mem_oe_n  <= 1'b1;
          mem_ub_n  <= 1'b1;
          mem_lb_n  <= 1'b1;
          state     <= ST_IDLE;
        end
        ST_RECOV: if (ph_done) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R7
  no_bus_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> mem_oe_n);

  // R4
  we_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce1_n && mem_ce2 && dq_oe));

  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (dq_oe && $stable(dq_out) && $stable(mem_addr)));

  // R2
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R3
  idle_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n &&
                   mem_ub_n && mem_lb_n && !dq_oe));

  // R6
  rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int CLK_NS  = 20;
  localparam int WC_NS   = 130;
  localparam int BOOT_NS = 500;
  localparam int PWE_NS  = 35;
  localparam int SD_NS   = 25;
  localparam int AW_NS   = 40;
  localparam int HZ_NS   = 15;
  localparam int AA_NS   = 45;
  localparam int BOOT_C  = (BOOT_NS + CLK_NS - 1) / CLK_NS;
  localparam int WC_C    = (WC_NS + CLK_NS - 1) / CLK_NS;
  localparam int AA_C    = (AA_NS + CLK_NS - 1) / CLK_NS;
  localparam int N_WR    = WC_C;   // strobe phases 1+2+1 = 4 < 7
  localparam int N_RD    = AA_C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n;
  logic [18:0] mem_addr;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic [15:0] dq_in;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl #(
    .CLK_NS(CLK_NS), .T_WC_NS(WC_NS), .T_PWE_NS(PWE_NS), .T_AW_NS(AW_NS),
    .T_SD_NS(SD_NS), .T_AA_NS(AA_NS), .T_HZWE_NS(HZ_NS), .T_BOOT_NS(BOOT_NS)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_addr(mem_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Behavioural memory behind the pad (indexed by low address byte).
  logic [15:0] smem   [0:255];
  logic [15:0] golden [0:255];
  logic [15:0] exp_q [$];

  always_comb begin
    if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n)
      dq_in = {mem_ub_n ? 8'h00 : smem[mem_addr[7:0]][15:8],
               mem_lb_n ? 8'h00 : smem[mem_addr[7:0]][7:0]};
    else
      dq_in = 16'h0000;
  end

  // Reference model state
  int boot_left;
  int busy;
  int rcount;
  bit rv_flag;
  bit started;

  // Pad monitor state
  bit          p_wact;
  logic [18:0] p_addr;
  logic [15:0] p_out;
  logic        p_ub, p_lb, p_we, p_sel;
  int we_lo, sd_cnt, aw_cnt, turn_cnt, since_sel;
  bit last_was_wr;

  always @(negedge clk) begin
    bit exp_rdy, sel, wact;
    if (!rst_n) begin
      boot_left = BOOT_C + 1; busy = 0; rcount = 0; rv_flag = 0; started = 1;
      p_wact = 0; p_addr = '0; p_out = '0; p_ub = 1; p_lb = 1; p_we = 1; p_sel = 0;
      we_lo = 0; sd_cnt = 0; aw_cnt = 0; turn_cnt = 0; since_sel = 1000; last_was_wr = 0;
    end else begin
      // ---- cycle comparison against model ----
      exp_rdy = (boot_left == 0) && (busy == 0);
      check(req_ready == exp_rdy, (boot_left > 0) ? "R1" : "R2", "req_ready",
            32'(req_ready), 32'(exp_rdy));
      check(rsp_valid == rv_flag, "R6", "rsp_valid", 32'(rsp_valid), 32'(rv_flag));
      if (rv_flag && exp_q.size() > 0) begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(rsp_data == e, "R5", "rsp_data", 32'(rsp_data), 32'(e));
      end
      if (exp_rdy || boot_left > 0)
        check(mem_ce1_n && !mem_ce2 && mem_we_n && mem_oe_n && mem_ub_n && mem_lb_n && !dq_oe,
              "R3", "parked strobes",
              {26'd0, mem_ce1_n, mem_ce2, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n},
              32'h2F);
      check(!(dq_oe && !mem_oe_n), "R7", "drive while output enabled",
            32'({dq_oe, mem_oe_n}), 32'h0);

      // ---- pad timing monitor ----
      sel  = !mem_ce1_n && mem_ce2;
      wact = sel && !mem_we_n && (!mem_ub_n || !mem_lb_n);
      if (sel && !p_sel) begin
        if (last_was_wr)
          check(since_sel >= WC_C, "R8", "write cycle clocks", 32'(since_sel), 32'(WC_C));
        check(mem_addr == req_addr, "R9", "address on select", 32'(mem_addr), 32'(req_addr));
        last_was_wr = req_write;
        since_sel = 0;
      end
      if (!mem_we_n && p_we)
        check(turn_cnt * CLK_NS >= HZ_NS && dq_oe, "R4", "turnaround before WE low",
              32'(turn_cnt), 32'((HZ_NS + CLK_NS - 1) / CLK_NS));
      if (p_wact && !wact) begin
        check(we_lo * CLK_NS >= PWE_NS, "R8", "WE low clocks", 32'(we_lo), 32'(PWE_NS / CLK_NS + 1));
        check(sd_cnt * CLK_NS >= SD_NS, "R8", "data setup clocks", 32'(sd_cnt), 32'(2));
        check(aw_cnt * CLK_NS >= AW_NS, "R8", "address setup clocks", 32'(aw_cnt), 32'(2));
        check(dq_oe && dq_out == p_out && mem_addr == p_addr, "R4", "hold after WE rise",
              32'(dq_out), 32'(p_out));
        if (!p_lb) smem[p_addr[7:0]][7:0]  = p_out[7:0];
        if (!p_ub) smem[p_addr[7:0]][15:8] = p_out[15:8];
      end
      // counters for the next cycle
      we_lo    = !mem_we_n ? we_lo + 1 : 0;
      sd_cnt   = dq_oe ? ((dq_out == p_out && sd_cnt > 0) ? sd_cnt + 1 : 1) : 0;
      aw_cnt   = sel ? ((mem_addr == p_addr && aw_cnt > 0) ? aw_cnt + 1 : 1) : 0;
      turn_cnt = (sel && mem_oe_n && mem_we_n && !dq_oe) ? turn_cnt + 1 : 0;
      since_sel++;
      p_wact = wact; p_addr = mem_addr; p_out = dq_out;
      p_ub = mem_ub_n; p_lb = mem_lb_n; p_we = mem_we_n; p_sel = sel;

      // ---- model advance for the next edge ----
      rv_flag = (rcount == 1);
      if (rcount > 0) rcount--;
      if (boot_left > 0) boot_left--;
      else if (busy > 0) busy--;
      else if (exp_rdy && req_valid) begin
        logic [7:0] ix;
        ix = req_addr[7:0];
        if (req_write) begin
          busy = N_WR;
          if (req_be[0]) golden[ix][7:0]  = req_wdata[7:0];
          if (req_be[1]) golden[ix][15:8] = req_wdata[15:8];
        end else begin
          busy = N_RD;
          rcount = N_RD;
          exp_q.push_back({req_be[1] ? golden[ix][15:8] : 8'h00,
                           req_be[0] ? golden[ix][7:0]  : 8'h00});
        end
      end
    end
  end

  task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                       input logic [1:0] be);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      smem[i] = 16'h0000;
      golden[i] = 16'h0000;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1: request waits through the startup count
    issue(1'b1, 19'h00012, 16'hA5C3, 2'b11);
    issue(1'b0, 19'h00012, 16'h0000, 2'b11);
    // R5: single-lane writes keep the other byte
    issue(1'b1, 19'h7FFFF, 16'h1234, 2'b11);
    issue(1'b1, 19'h7FFFF, 16'hBEEF, 2'b10);
    issue(1'b0, 19'h7FFFF, 16'h0000, 2'b11);
    issue(1'b1, 19'h00012, 16'h5A77, 2'b01);
    issue(1'b0, 19'h00012, 16'h0000, 2'b01);
    issue(1'b0, 19'h00012, 16'h0000, 2'b10);
    issue(1'b1, 19'h40080, 16'hFFFF, 2'b11);
    issue(1'b0, 19'h40080, 16'h0000, 2'b11);
    issue(1'b0, 19'h00000, 16'h0000, 2'b11);
    // R2: back-to-back traffic under back-pressure
    for (int i = 0; i < 16; i++)
      issue(1'b1, 19'((i * 8191 + 3) & 19'h7FF00) | 19'(i + 32),
            16'((i * 16'h1111) ^ 16'h3C5A), 2'((i % 3) + 1));
    for (int i = 0; i < 16; i++)
      issue(1'b0, 19'((i * 8191 + 3) & 19'h7FF00) | 19'(i + 32), 16'h0, 2'b11);
    repeat (12) @(posedge clk);
    check(exp_q.size() == 0, "R6", "responses outstanding", 32'(exp_q.size()), 32'd0);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

endmodule